// File: doc/BRIEF.md
# Serial PLL Synthesizer Channel Programmer

This block turns a tuning or power request into the register writes that a 5.8 GHz video-transmitter synthesizer expects. The link to the synthesizer has only three wires: serial data, serial clock and an active-low latch enable. Nothing is read back. Each register write is one 25-bit frame. The frame carries, least significant bit first, a 4-bit register address, a write flag and a 20-bit data field. A rising edge on the latch enable commits the frame.

A command names one of three operations:

- a band and channel index, resolved through a built-in table of 40 frequencies;
- a direct frequency in MHz;
- an RF power on/off flag.

A tuning command always writes the reference-divider register first and the frequency register second. A power command writes the power-amplifier control register once. The bit rate is set by a parameter that gives the number of system clocks in each half of a serial bit. The block reports `busy` while it is working and gives a one-cycle `done` pulse when it finishes.

Top module: `vtx_synth_prog`

## Requirements
- R1: Out of reset, `ser_le` is 1 and `ser_clk`, `ser_data`, `busy` and `done` are 0.
- R2: Each frame is exactly 25 `ser_clk` rising edges inside one low window of `ser_le`. The bits are, in transmission order: address bits 0..3, then a 1 (the write flag), then data bits 0..19.
- R3: `ser_data` is set up while `ser_clk` is low and does not change while `ser_clk` is high. Every high phase and every low phase of `ser_clk` inside a frame lasts exactly `HALF_CYC` clocks, and that includes the setup phase after `ser_le` falls.
- R4: A tuning command (`cmd_kind` 0 or 1) sends two frames. The first goes to address 0 with data 400. The second goes to address 1 with the frequency word.
- R5: For a frequency f in MHz, with q = 25·f, the frequency word is ((q div 64) << 7) | (q mod 64).
- R6: A direct frequency (`cmd_kind` = 1) is clamped to the range 5600..5950 MHz before the word is formed.
- R7: A band/channel command (`cmd_kind` = 0) uses band index 0..4 and channel index 0..7. The bands hold these frequencies in MHz, channel 0 first:
  - band 0: 5865 down to 5725 in steps of 20;
  - band 1: 5733 up to 5866 in steps of 19;
  - band 2: 5705, 5685, 5665, 5645, 5885, 5905, 5925, 5945;
  - band 3: 5740 up to 5880 in steps of 20;
  - band 4: 5658 up to 5917 in steps of 37.
- R8: A band index above 4 is treated as 4, and a channel index above 7 is treated as 7.
- R9: A power command (`cmd_kind` = 2) sends one frame to address 7. The data is 0x4FBD when `cmd_pwr_on` is 1 and 0x407D when it is 0.
- R10: `busy` rises in the cycle after a command is accepted. It falls when the last frame's latch rise and its trailing `HALF_CYC` guard are over, and `done` is high for that one cycle only.
- R11: A command presented while `busy` is 1 is ignored, and so is `cmd_kind` = 3. Neither one causes a frame, a change in `busy` or a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe; sampled only when idle |
| cmd_kind | input | 2 | 0 band/channel, 1 frequency, 2 power, 3 none |
| cmd_band | input | 3 | Band index |
| cmd_chan | input | 4 | Channel index |
| cmd_freq | input | 13 | Requested frequency in MHz |
| cmd_pwr_on | input | 1 | RF power flag for power commands |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_le | output | 1 | Latch enable, low during a frame |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Bugs inside the block show up at the port level, and only late.

- A wrong frequency word, a misordered table entry or a missing clamp shows up only in the data field of the second frame. That field is fully known about 104·`HALF_CYC` clocks after acceptance, so the bench decodes every frame from the pins and compares it as a whole 25-bit word.
- A bit-counter or phase-counter error changes the number of clock rises per latch window or the width of a clock phase. It is visible within the frame where it occurs.
- A bad busy or ignore path shows up as an extra frame or a missing `done` pulse within one command's duration.

// File: rtl/vtx_prog_pkg.sv
package vtx_prog_pkg;

  localparam int FRAME_BITS = 25;
  localparam int DATA_BITS  = 20;
  localparam int ADDR_BITS  = 4;
  localparam int MHZ_LO     = 5600;
  localparam int MHZ_HI     = 5950;
  localparam int REF_COUNT  = 400;
  localparam int PA_BASE    = 'h4FBD;
  localparam logic [ADDR_BITS-1:0] REG_REF  = 4'd0;
  localparam logic [ADDR_BITS-1:0] REG_TUNE = 4'd1;
  localparam logic [ADDR_BITS-1:0] REG_PA   = 4'd7;

  typedef enum logic [1:0] {
    CMD_CHAN  = 2'd0,
    CMD_FREQ  = 2'd1,
    CMD_POWER = 2'd2,
    CMD_NONE  = 2'd3
  } cmd_kind_e;

  typedef logic [FRAME_BITS-1:0] frame_t;

  // Transmission order is bit 0 first: address, write flag, data.
  function automatic frame_t pack_frame(input logic [ADDR_BITS-1:0] addr,
                                        input logic [DATA_BITS-1:0] data);
    return {data, 1'b1, addr};
  endfunction

  function automatic int clamp_mhz(input int f);
    if (f < MHZ_LO) return MHZ_LO;
    if (f > MHZ_HI) return MHZ_HI;
    return f;
  endfunction

  function automatic logic [DATA_BITS-1:0] tune_word(input int f);
    int q;
    int n;
    int a;
    q = f * 25;
    n = q / 64;
    a = q % 64;
    return DATA_BITS'((n << 7) | a);
  endfunction

  function automatic logic [DATA_BITS-1:0] pa_word(input logic on);
    int w;
    w = PA_BASE;
    if (!on) begin
      w = w | 'h0040;
      w = w & ~('h0F80);
    end
    return DATA_BITS'(w);
  endfunction

  // Each band follows a simple arithmetic rule, so no stored table is needed.
  function automatic int chan_mhz(input int band, input int ch);
    case (band)
      0:       return 5865 - 20 * ch;
      1:       return 5733 + 19 * ch;
      2:       return (ch < 4) ? (5705 - 20 * ch) : (5885 + 20 * (ch - 4));
      3:       return 5740 + 20 * ch;
      default: return 5658 + 37 * ch;
    endcase
  endfunction

endpackage

// File: rtl/vtx_phase_timer.sv
module vtx_phase_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic phase_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign phase_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || phase_end) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/vtx_cmd_decode.sv
module vtx_cmd_decode
  import vtx_prog_pkg::*;
#(
  parameter int BANDS  = 5,
  parameter int CHANS  = 8,
  parameter int BAND_W = 3,
  parameter int CHAN_W = 4,
  parameter int FREQ_W = 13
) (
  input  logic [1:0]        kind,
  input  logic [BAND_W-1:0] band,
  input  logic [CHAN_W-1:0] chan,
  input  logic [FREQ_W-1:0] freq,
  input  logic              pwr_on,
  output logic              usable,
  output logic              two_frames,
  output frame_t            frame_a,
  output frame_t            frame_b
);
  int band_i;
  int chan_i;
  int mhz;

  always_comb begin
    band_i = (int'(band) > BANDS - 1) ? BANDS - 1 : int'(band);
    chan_i = (int'(chan) > CHANS - 1) ? CHANS - 1 : int'(chan);
    if (cmd_kind_e'(kind) == CMD_CHAN) mhz = chan_mhz(band_i, chan_i);
    else                               mhz = clamp_mhz(int'(freq));
    usable     = (cmd_kind_e'(kind) != CMD_NONE);
    two_frames = (cmd_kind_e'(kind) != CMD_POWER);
    if (cmd_kind_e'(kind) == CMD_POWER) begin
      frame_a = pack_frame(REG_PA, pa_word(pwr_on));
      frame_b = '0;
    end else begin
      frame_a = pack_frame(REG_REF, DATA_BITS'(REF_COUNT));
      frame_b = pack_frame(REG_TUNE, tune_word(mhz));
    end
  end
endmodule

// File: rtl/vtx_frame_shifter.sv
module vtx_frame_shifter
  import vtx_prog_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  frame_t frame,
  output logic   ser_data,
  output logic   ser_clk,
  output logic   ser_le,
  output logic   idle,
  output logic   fin
);
  localparam int IW = $clog2(FRAME_BITS + 1);
  localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);

  typedef enum logic [2:0] { SH_IDLE, SH_SETUP, SH_HI, SH_LO, SH_GAP } sh_state_e;

  sh_state_e     st;
  frame_t        shreg;
  logic [IW-1:0] idx;
  logic          phase_end;
  logic          launch_now;
  logic          clk_d;
  logic [IW-1:0] rise_cnt;

  assign idle       = (st == SH_IDLE);
  assign launch_now = idle && start;

  vtx_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (launch_now),
    .phase_end(phase_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SH_IDLE;
      shreg    <= '0;
      idx      <= '0;
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
      ser_le   <= 1'b1;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SH_IDLE: if (start) begin
          shreg    <= frame;
          idx      <= '0;
          ser_le   <= 1'b0;
          ser_data <= frame[0];
          st       <= SH_SETUP;
        end
        SH_SETUP: if (phase_end) begin
          ser_clk <= 1'b1;
          st      <= SH_HI;
        end
        SH_HI: if (phase_end) begin
          ser_clk  <= 1'b0;
          ser_data <= (idx == LAST_BIT) ? 1'b0 : shreg[1];
          shreg    <= shreg >> 1;
          st       <= SH_LO;
        end
        SH_LO: if (phase_end) begin
          if (idx == LAST_BIT) begin
            ser_le <= 1'b1;
            st     <= SH_GAP;
          end else begin
            idx     <= idx + 1'b1;
            ser_clk <= 1'b1;
            st      <= SH_HI;
          end
        end
        SH_GAP: if (phase_end) begin
          fin <= 1'b1;
          st  <= SH_IDLE;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // Independent count of clock rises, used only to check frame length.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      clk_d <= ser_clk;
      if (launch_now)             rise_cnt <= '0;
      else if (ser_clk && !clk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_clk_inside_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !ser_le);
  assert_frame_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le) |-> (rise_cnt == IW'(FRAME_BITS)));
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
endmodule

// File: rtl/vtx_synth_prog.sv
module vtx_synth_prog
  import vtx_prog_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int BANDS    = 5,
  parameter int CHANS    = 8,
  parameter int BAND_W   = 3,
  parameter int CHAN_W   = 4,
  parameter int FREQ_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [BAND_W-1:0] cmd_band,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic [FREQ_W-1:0] cmd_freq,
  input  logic              cmd_pwr_on,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le,
  output logic              busy,
  output logic              done
);
  logic   dec_usable;
  logic   dec_two;
  frame_t dec_a;
  frame_t dec_b;
  frame_t hold_b;
  frame_t shift_frame;
  logic   second_pending;
  logic   launch;
  logic   send_b;
  logic   sh_idle;
  logic   sh_fin;
  logic   accept;

  vtx_cmd_decode #(
    .BANDS(BANDS), .CHANS(CHANS), .BAND_W(BAND_W), .CHAN_W(CHAN_W), .FREQ_W(FREQ_W)
  ) u_dec (
    .kind      (cmd_kind),
    .band      (cmd_band),
    .chan      (cmd_chan),
    .freq      (cmd_freq),
    .pwr_on    (cmd_pwr_on),
    .usable    (dec_usable),
    .two_frames(dec_two),
    .frame_a   (dec_a),
    .frame_b   (dec_b)
  );

  assign accept = cmd_valid && !busy && dec_usable;

  frame_t hold_a;
  assign shift_frame = send_b ? hold_b : hold_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      done           <= 1'b0;
      launch         <= 1'b0;
      send_b         <= 1'b0;
      second_pending <= 1'b0;
      hold_a         <= '0;
      hold_b         <= '0;
    end else begin
      done   <= 1'b0;
      launch <= 1'b0;
      if (accept) begin
        busy           <= 1'b1;
        hold_a         <= dec_a;
        hold_b         <= dec_b;
        second_pending <= dec_two;
        send_b         <= 1'b0;
        launch         <= 1'b1;
      end else if (busy && sh_fin) begin
        if (second_pending) begin
          second_pending <= 1'b0;
          send_b         <= 1'b1;
          launch         <= 1'b1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  vtx_frame_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch),
    .frame   (shift_frame),
    .ser_data(ser_data),
    .ser_clk (ser_clk),
    .ser_le  (ser_le),
    .idle    (sh_idle),
    .fin     (sh_fin)
  );

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |-> (ser_le && !ser_clk && sh_idle));
  assert_hold_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hold_a) && $stable(hold_b)));
  assert_launch_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> sh_idle);
endmodule

// File: tb/sim_vtx_synth_prog.sv
module sim_vtx_synth_prog;
  localparam int HALF = 3;
  localparam int NV   = 14;
  localparam int MAXF = 256;

  // Stimulus table: kind, band, chan, freq, power flag, expected tuned MHz or PA data.
  localparam int V_KIND [NV] = '{1,1,1,1,1,0,0,0,0,0,0,0,2,2};
  localparam int V_BAND [NV] = '{0,0,0,0,0,0,1,2,3,4,7,0,0,0};
  localparam int V_CHAN [NV] = '{0,0,0,0,0,0,7,4,3,7,2,12,0,0};
  localparam int V_FREQ [NV] = '{5800,5600,5950,5000,7000,0,0,0,0,0,0,0,0,0};
  localparam int V_PWR  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,0};
  localparam int V_EXP  [NV] = '{5800,5600,5950,5600,5950,5865,5866,5885,5800,5917,
                                 5732,5725,'h4FBD,'h407D};
  localparam string V_REQ [NV] = '{"R5","R4","R6","R6","R6","R7","R7","R7","R7","R7",
                                   "R8","R8","R9","R9"};

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_kind = 0;
  logic [2:0] cmd_band = 0;
  logic [3:0] cmd_chan = 0;
  logic [12:0] cmd_freq = 0;
  logic cmd_pwr_on = 0;
  logic ser_data, ser_clk, ser_le, busy, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vtx_synth_prog #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_band(cmd_band), .cmd_chan(cmd_chan), .cmd_freq(cmd_freq),
    .cmd_pwr_on(cmd_pwr_on), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_le(ser_le), .busy(busy), .done(done)
  );

  // Pin-level frame decoder and timing monitor.
  logic [24:0] cap [MAXF];
  int capn [MAXF];
  int ncap = 0;
  logic [24:0] shbits = 0;
  int nb = 0;
  logic prev_c = 0, prev_le = 1, held = 0;
  int hi_cnt = 0, lo_cnt = 0, timing_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ser_le && prev_le) begin nb = 0; lo_cnt = 0; end
      if (ser_clk && !prev_c) begin
        if (lo_cnt != HALF) timing_bad++;
        if (nb < 25) shbits[nb] = ser_data;
        nb++;
        held = ser_data;
        hi_cnt = 0;
      end
      if (ser_clk && prev_c && ser_data != held) timing_bad++;
      if (!ser_clk && prev_c) begin
        if (hi_cnt != HALF) timing_bad++;
        lo_cnt = 0;
      end
      if (ser_clk) hi_cnt++;
      if (!ser_clk && !ser_le) lo_cnt++;
      if (ser_le && !prev_le && ncap < MAXF) begin
        cap[ncap] = shbits;
        capn[ncap] = nb;
        ncap++;
      end
    end
    prev_c = ser_clk;
    prev_le = ser_le;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bench_word(input int mhz);
    int q;
    q = mhz * 25;
    return (q / 64) * 128 + (q - (q / 64) * 64);
  endfunction

  function automatic logic [24:0] bench_frame(input int addr, input int data);
    return 25'(data * 32 + 16 + addr);
  endfunction

  task automatic issue(input int kind, input int band, input int chan, input int f, input int p);
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 2'(kind); cmd_band = 3'(band); cmd_chan = 4'(chan);
    cmd_freq = 13'(f); cmd_pwr_on = p[0];
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ser_le == 1 && ser_clk == 0 && ser_data == 0 && busy == 0 && done == 0, "R1",
          {ser_le, ser_clk, ser_data, busy, done}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(ser_le == 1 && busy == 0, "R1", {ser_le, busy}, 2'b10);

    for (int v = 0; v < NV; v++) begin
      base = ncap;
      issue(V_KIND[v], V_BAND[v], V_CHAN[v], V_FREQ[v], V_PWR[v]);
      check(busy == 1, "R10", busy, 1);
      wait_done(seen);
      check(seen && !busy, "R10", {seen, busy}, 2'b10);
      if (V_KIND[v] == 2) begin
        check(ncap - base == 1, "R9", ncap - base, 1);
        check(capn[base] == 25, "R2", capn[base], 25);
        check(cap[base] == bench_frame(7, V_EXP[v]), V_REQ[v], cap[base],
              bench_frame(7, V_EXP[v]));
      end else begin
        check(ncap - base == 2, "R4", ncap - base, 2);
        check(capn[base] == 25 && capn[base+1] == 25, "R2", capn[base+1], 25);
        check(cap[base] == bench_frame(0, 400), "R4", cap[base], bench_frame(0, 400));
        check(cap[base+1] == bench_frame(1, bench_word(V_EXP[v])), V_REQ[v], cap[base+1],
              bench_frame(1, bench_word(V_EXP[v])));
      end
      @(negedge clk);
      check(done == 0, "R10", done, 0);
    end

    // R11: command while busy is ignored
    base = ncap;
    issue(1, 0, 0, 5700, 0);
    repeat (20) @(negedge clk);
    issue(2, 0, 0, 0, 1);
    wait_done(seen);
    repeat (300) @(negedge clk);
    check(ncap - base == 2, "R11", ncap - base, 2);
    check(cap[base+1] == bench_frame(1, bench_word(5700)), "R11", cap[base+1],
          bench_frame(1, bench_word(5700)));
    check(busy == 0 && done == 0, "R11", {busy, done}, 0);

    // R11: kind 3 is ignored
    base = ncap;
    issue(3, 0, 0, 5800, 1);
    check(busy == 0, "R11", busy, 0);
    repeat (300) @(negedge clk);
    check(ncap == base && ser_le == 1, "R11", ncap - base, 0);

    // R3: phase widths and data hold over the whole run
    check(timing_bad == 0, "R3", timing_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule